// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of one SDRAM read or write burst. A column command loads a 9-bit start column together with a length code and an ordering select. From the next cycle on, the block presents one column address per beat, marked by a valid flag. Beats are consumed on cycles where the advance enable is high. With the enable low, the clock is suspended and the current beat is held.

Fixed-length bursts of 1, 2, 4 or 8 beats wrap inside their aligned boundary. Sequential order counts the low bits upward. Interleaved order XORs the low bits with the beat index. A full-page burst steps through all columns without end and finishes only on a stop request. A stop request ends any burst. A new column command may arrive in any cycle and always replaces the burst in progress. A one-cycle done pulse marks a burst that ended by length or by stop.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `beat_vld_o` and `done_o` are 0 and `col_o` is 0.
- R2: When `start_i` is high at a clock edge, in the next cycle `beat_vld_o` is 1 and `col_o` equals the sampled `col_i`. The length code `blen_i` encodes 000=1, 001=2, 010=4, 011=8 and 111=full page. `itlv_i`=1 selects interleaved order and 0 selects sequential order.
- R3: In sequential order, each consumed beat increments the low log2(BL) bits of the address, wrapping inside the burst. The upper bits stay equal to those of the start column.
- R4: In interleaved order, beat k carries the start column with its low log2(BL) bits XORed with k. The upper bits are unchanged.
- R5: A full-page burst steps the column up by one per consumed beat, wraps from 511 to 0 and never ends by itself. With full page selected, `itlv_i` is ignored and the order is sequential.
- R6: While `beat_vld_o` is 1 and `adv_i` is 0, with no start or stop, `col_o` holds, `beat_vld_o` stays 1 and the beat is not counted.
- R7: After BL beats of a fixed-length burst have been consumed, `beat_vld_o` falls in the next cycle and `done_o` is 1 for exactly that one cycle.
- R8: A `stop_i` pulse during a burst makes `beat_vld_o` 0 and `done_o` 1 in the next cycle, whatever `adv_i` is. While idle, `stop_i` has no effect and gives no done pulse.
- R9: A start during a burst restarts at the new column with the new mode and gives no done pulse for the old burst. A start outranks a stop in the same cycle.
- R10: The unused length codes 100, 101 and 110 give a one-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Column command: load start column and mode |
| col_i | input | 9 | Start column |
| blen_i | input | 3 | Burst length code |
| itlv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Burst stop request |
| adv_i | input | 1 | Advance enable; low suspends the burst |
| col_o | output | 9 | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is presented on `col_o` |
| done_o | output | 1 | One-cycle pulse after a burst ends |

## Verification
The bench starts bursts at unaligned columns so that wrapping shows. A design that carried into the upper bits, or that ignored the XOR order, would produce a column outside the aligned block. A full-page burst starts near column 511 with interleave requested. This catches a counter that saturates instead of wrapping, and one that honours the interleave bit in full-page mode. Suspend cycles placed mid-burst expose a design that counts beats while the enable is low. A start issued together with a stop, in the middle of another burst, exposes a spurious done pulse or a stop that wins over the new command. Stops while idle and the unused length codes cover the remaining edge cases.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [2:0] {
    BLEN_1  = 3'b000,
    BLEN_2  = 3'b001,
    BLEN_4  = 3'b010,
    BLEN_8  = 3'b011,
    BLEN_FP = 3'b111
  } blen_e;
endpackage

// File: rtl/bcs_len_dec.sv
module bcs_len_dec
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             itlv_req_i,
  output logic [COL_W-1:0] mask_o,
  output logic             fp_o,
  output logic             itlv_o
);
  always_comb begin
    mask_o = '0;
    fp_o   = 1'b0;
    unique case (code_i)
      BLEN_2:  mask_o = COL_W'(1);
      BLEN_4:  mask_o = COL_W'(3);
      BLEN_8:  mask_o = COL_W'(7);
      BLEN_FP: begin
        mask_o = '1;
        fp_o   = 1'b1;
      end
      default: mask_o = '0;
    endcase
    // full page runs in sequential order only
    itlv_o = itlv_req_i & ~fp_o;
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             itlv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] seq_w;
  logic [COL_W-1:0] xor_w;
  logic [COL_W-1:0] low_w;

  assign seq_w = base_i + idx_i;
  assign xor_w = base_i ^ idx_i;
  assign low_w = itlv_i ? xor_w : seq_w;

  // bits inside the burst window move, bits above it keep the base
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign addr_o[b] = mask_i[b] ? low_w[b] : base_i[b];
  end
endmodule

// File: rtl/bcs_beat_ctr.sv
module bcs_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             adv_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             fp_i,
  output logic [COL_W-1:0] idx_o,
  output logic             step_o,
  output logic             active_o,
  output logic             done_o
);
  logic last_w;
  logic end_w;

  assign last_w = ~fp_i & (idx_o == mask_i);
  assign end_w  = active_o & ~start_i & (stop_i | (adv_i & last_w));
  assign step_o = active_o & ~start_i & ~stop_i & adv_i & ~last_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o    <= '0;
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= end_w;
      if (start_i) begin
        idx_o    <= '0;
        active_o <= 1'b1;
      end else if (end_w) begin
        active_o <= 1'b0;
      end else if (step_o) begin
        idx_o <= idx_o + COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       blen_i,
  input  logic             itlv_i,
  input  logic             stop_i,
  input  logic             adv_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_vld_o,
  output logic             done_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_fp;
  logic             dec_itlv;

  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             fp_q;
  logic             itlv_q;

  logic [COL_W-1:0] idx;
  logic             step;
  logic [COL_W-1:0] nxt_addr;

  bcs_len_dec #(.COL_W(COL_W)) u_dec (
    .code_i     (blen_i),
    .itlv_req_i (itlv_i),
    .mask_o     (dec_mask),
    .fp_o       (dec_fp),
    .itlv_o     (dec_itlv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      fp_q   <= 1'b0;
      itlv_q <= 1'b0;
    end else if (start_i) begin
      base_q <= col_i;
      mask_q <= dec_mask;
      fp_q   <= dec_fp;
      itlv_q <= dec_itlv;
    end
  end

  bcs_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .adv_i    (adv_i),
    .mask_i   (mask_q),
    .fp_i     (fp_q),
    .idx_o    (idx),
    .step_o   (step),
    .active_o (beat_vld_o),
    .done_o   (done_o)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base_q),
    .idx_i  (idx + COL_W'(1)),
    .mask_i (mask_q),
    .itlv_i (itlv_q),
    .addr_o (nxt_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o <= '0;
    end else if (start_i) begin
      col_o <= col_i;
    end else if (step) begin
      col_o <= nxt_addr;
    end
  end
endmodule

// File: rtl/bcs_chk.sv
module bcs_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             stop_i,
  input logic             adv_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             beat_vld_o,
  input logic             done_o
);
  p_start_load_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (beat_vld_o && col_o == $past(col_i)));

  p_suspend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && !adv_i && !start_i && !stop_i) |=> (beat_vld_o && $stable(col_o)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !beat_vld_o);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (beat_vld_o && stop_i && !start_i) |=> (done_o && !beat_vld_o));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!beat_vld_o && !start_i) |=> (!beat_vld_o && !done_o));

  p_preempt_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !done_o);
endmodule

bind burst_col_seq bcs_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .adv_i      (adv_i),
  .col_i      (col_i),
  .col_o      (col_o),
  .beat_vld_o (beat_vld_o),
  .done_o     (done_o)
);

// File: tb/sim_burst_col_seq.sv
`timescale 1ns/1ps
module sim_burst_col_seq;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i;
  logic [8:0] col_i;
  logic [2:0] blen_i;
  logic       itlv_i;
  logic       stop_i;
  logic       adv_i;
  logic [8:0] col_o;
  logic       beat_vld_o;
  logic       done_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(9)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .col_i(col_i), .blen_i(blen_i),
    .itlv_i(itlv_i), .stop_i(stop_i), .adv_i(adv_i), .col_o(col_o),
    .beat_vld_o(beat_vld_o), .done_o(done_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic logic [8:0] exp_addr(input logic [8:0] s, input int k,
                                          input logic [2:0] code, input logic itl);
    logic [8:0] m;
    m = 9'(len_of(code) - 1);
    if (code == 3'b111) return 9'((int'(s) + k) % 512);
    if (itl) return (s & ~m) | ((s ^ 9'(k)) & m);
    return (s & ~m) | (9'(int'(s) + k) & m);
  endfunction

  task automatic issue(input logic [8:0] c, input logic [2:0] code, input logic itl);
    start_i = 1'b1; col_i = c; blen_i = code; itlv_i = itl;
    step();
    start_i = 1'b0;
    chk(beat_vld_o === 1'b1, "R2 valid after start", int'(beat_vld_o), 1);
    chk(col_o === c, "R2 first column", int'(col_o), int'(c));
  endtask

  task automatic run_burst(input logic [8:0] c, input logic [2:0] code,
                           input logic itl, input string req);
    int n;
    n = len_of(code);
    issue(c, code, itl);
    adv_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      logic [8:0] e;
      e = exp_addr(c, k, code, itl);
      chk(col_o === e && beat_vld_o === 1'b1, req, int'(col_o), int'(e));
      step();
    end
    chk(beat_vld_o === 1'b0, "R7 valid drops at end", int'(beat_vld_o), 0);
    chk(done_o === 1'b1, "R7 done after last beat", int'(done_o), 1);
    adv_i = 1'b0;
    step();
    chk(done_o === 1'b0, "R7 done lasts one cycle", int'(done_o), 0);
  endtask

  task automatic t_reset();
    rst = 1'b1; start_i = 0; col_i = 0; blen_i = 0; itlv_i = 0; stop_i = 0; adv_i = 0;
    step(); step();
    rst = 1'b0;
    step();
    chk(beat_vld_o === 1'b0, "R1 valid", int'(beat_vld_o), 0);
    chk(done_o === 1'b0, "R1 done", int'(done_o), 0);
    chk(col_o === 9'd0, "R1 column", int'(col_o), 0);
  endtask

  task automatic t_suspend();
    issue(9'h00E, 3'b010, 1'b0);
    adv_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step();
      chk(col_o === 9'h00E && beat_vld_o === 1'b1, "R6 hold while suspended", int'(col_o), 14);
      chk(done_o === 1'b0, "R6 no done while suspended", int'(done_o), 0);
    end
    adv_i = 1'b1; step();
    chk(col_o === 9'h00F, "R6 resume beat 1", int'(col_o), 15);
    adv_i = 1'b0; step();
    chk(col_o === 9'h00F, "R6 hold beat 1", int'(col_o), 15);
    adv_i = 1'b1; step();
    chk(col_o === 9'h00C, "R3 wrap beat 2", int'(col_o), 12);
    step();
    chk(col_o === 9'h00D, "R3 beat 3", int'(col_o), 13);
    step();
    chk(done_o === 1'b1 && beat_vld_o === 1'b0, "R7 end after suspend", int'(done_o), 1);
    adv_i = 1'b0; step();
  endtask

  task automatic t_full_page();
    issue(9'h1FC, 3'b111, 1'b1);
    adv_i = 1'b1;
    for (int k = 0; k < 10; k++) begin
      logic [8:0] e;
      e = 9'((508 + k) % 512);
      chk(col_o === e && beat_vld_o === 1'b1, "R5 full page wrap", int'(col_o), int'(e));
      step();
    end
    stop_i = 1'b1; adv_i = 1'b0;
    step();
    stop_i = 1'b0;
    chk(done_o === 1'b1 && beat_vld_o === 1'b0, "R8 stop ends full page", int'(done_o), 1);
    step();
    chk(done_o === 1'b0, "R8 done one cycle", int'(done_o), 0);
  endtask

  task automatic t_stop_mid_and_idle();
    issue(9'h020, 3'b011, 1'b0);
    adv_i = 1'b1; step(); step();
    chk(col_o === 9'h022, "R3 beat 2 before stop", int'(col_o), 34);
    stop_i = 1'b1; adv_i = 1'b0;
    step();
    chk(done_o === 1'b1 && beat_vld_o === 1'b0, "R8 stop mid burst", int'(done_o), 1);
    step();
    chk(done_o === 1'b0 && beat_vld_o === 1'b0, "R8 stop while idle ignored", int'(done_o), 0);
    stop_i = 1'b0;
    step();
    chk(beat_vld_o === 1'b0, "R8 still idle", int'(beat_vld_o), 0);
  endtask

  task automatic t_preempt();
    issue(9'h010, 3'b011, 1'b0);
    adv_i = 1'b1; step(); step();
    chk(col_o === 9'h012, "R9 old burst beat 2", int'(col_o), 18);
    start_i = 1'b1; stop_i = 1'b1; col_i = 9'h037; blen_i = 3'b010; itlv_i = 1'b1;
    step();
    start_i = 1'b0; stop_i = 1'b0;
    chk(done_o === 1'b0, "R9 no done on preempt", int'(done_o), 0);
    chk(beat_vld_o === 1'b1 && col_o === 9'h037, "R9 start beats stop", int'(col_o), 55);
    step();
    chk(col_o === 9'h036, "R9 new mode beat 1", int'(col_o), 54);
    step();
    chk(col_o === 9'h035, "R4 beat 2", int'(col_o), 53);
    step();
    chk(col_o === 9'h034, "R4 beat 3", int'(col_o), 52);
    step();
    chk(done_o === 1'b1 && beat_vld_o === 1'b0, "R9 new burst ends at its length", int'(done_o), 1);
    adv_i = 1'b0; step();
  endtask

  initial begin
    t_reset();
    run_burst(9'h0A5, 3'b000, 1'b0, "R2 one beat");
    run_burst(9'h0A5, 3'b001, 1'b0, "R3 seq BL2");
    run_burst(9'h0A6, 3'b010, 1'b0, "R3 seq BL4");
    run_burst(9'h13D, 3'b011, 1'b0, "R3 seq BL8");
    run_burst(9'h0A6, 3'b010, 1'b1, "R4 interleave BL4");
    run_burst(9'h13D, 3'b011, 1'b1, "R4 interleave BL8");
    run_burst(9'h001, 3'b001, 1'b1, "R4 interleave BL2");
    run_burst(9'h0F3, 3'b100, 1'b1, "R10 code 100");
    run_burst(9'h0F3, 3'b110, 1'b0, "R10 code 110");
    t_suspend();
    t_full_page();
    t_stop_mid_and_idle();
    t_preempt();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule